// File: doc/BRIEF.md
# Subsystem Bus Slave Decoder

This block sits at the edge of a local microcontroller bus and turns its raw strobes into per-region access enables. The bus can run multiplexed, where address and data share eight lines and a latch strobe captures the address, or nonmultiplexed, where a dedicated input carries the low address byte. In multiplexed operation either strobe convention is accepted. In the Intel convention, an active-high latch pulse is followed by separate active-low read and write strobes. In the Zilog convention, an active-low address strobe is followed by an active-low data strobe qualified by a read/not-write level.

The 9-bit address is decoded into fixed regions: a 256-byte shared attribute RAM, eight configuration registers, a control register, a write-only clock-programming register, a UART register window and a bypass FIFO port. The block drives read and write enables for each region, passes write data through, and muxes read data onto the shared bus. It enables the bus driver only for a read of a readable location. The strobe inputs are sampled on the system clock, and the latched address lives in that clock domain.

Top module: `subsys_bus_decoder`

## Requirements
- R1: When `nomux_i` is 1, `addr_o` equals `{addr_hi_i, addr_lo_i}` and `ale_i` has no effect on it.
- R2: When `nomux_i` is 0 and `zstyle_i` is 0, the address `{addr_hi_i, ad_i}` is captured at the first clock edge that sees `ale_i` low after high. It is held unchanged until the next such fall.
- R3: When `nomux_i` is 0 and `zstyle_i` is 1, the address is captured at the first clock edge that sees `ale_i` high after low. It is held until the next such rise.
- R4: With `zstyle_i` 0, a read is `rd_ds_n_i` low with `wr_rnw_i` high, and a write is `wr_rnw_i` low with `rd_ds_n_i` high. When both are low, no access takes place.
- R5: With `zstyle_i` 1, a read is `rd_ds_n_i` low with `wr_rnw_i` high, and a write is `rd_ds_n_i` low with `wr_rnw_i` low.
- R6: Addresses 0 to 255 give `ram_re_o` on a read and `ram_we_o` on a write, and a read returns `ram_rdata_i`.
- R7: Addresses 256 to 263 set bit (address-256) of `cfg_re_o` on a read or of `cfg_we_o` on a write. A read returns `cfg_rdata_i`.
- R8: Address 272 gives `ctrl_re_o` or `ctrl_we_o`, and a read returns `ctrl_rdata_i`. Address 288 gives `clkp_we_o` on a write only.
- R9: A write to address 304 gives `mcr_we_o`. A read of addresses 304 to 311 gives `uart_re_o` with `uart_idx_o` equal to address-304 and returns `uart_rdata_i`. The index order is divisor low, interrupt enable, FIFO control, line control, modem control, line status, modem status, divisor high.
- R10: With `bypass_i` 1, a read of 320 gives `txf_re_o` and returns `txf_rdata_i`, and a write of 320 gives `rxf_we_o`. With `bypass_i` 0, address 320 is unmapped.
- R11: An unmapped address, a write to a read-only location or a read of a write-only location raises no enable, keeps `ad_oe_o` low and gives `ad_out_o` 0x00.
- R12: `ad_oe_o` is 1 only during a valid read of a readable location, and at most one region enable is active at a time.
- R13: During reset the latched address is 0 and no enable or output driver is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| nomux_i | input | 1 | 0 multiplexed bus, 1 separate address byte |
| zstyle_i | input | 1 | 0 Intel strobes, 1 Zilog strobes |
| ale_i | input | 1 | Address latch / address strobe |
| rd_ds_n_i | input | 1 | Read strobe (Intel) or data strobe (Zilog), active low |
| wr_rnw_i | input | 1 | Write strobe active low (Intel) or read/not-write level (Zilog) |
| addr_hi_i | input | 1 | Address bit 8 |
| addr_lo_i | input | 8 | Low address byte in nonmultiplexed mode |
| ad_i | input | 8 | Shared address/data lines, input side |
| ad_out_o | output | 8 | Read data toward the shared lines |
| ad_oe_o | output | 1 | Output enable for the shared lines |
| bypass_i | input | 1 | Enables the FIFO port at address 320 |
| addr_o | output | 9 | Effective address |
| wdata_o | output | 8 | Write data |
| ram_re_o | output | 1 | Attribute RAM read enable |
| ram_we_o | output | 1 | Attribute RAM write enable |
| ram_rdata_i | input | 8 | Attribute RAM read data |
| cfg_re_o | output | 8 | Configuration register read enables, one-hot |
| cfg_we_o | output | 8 | Configuration register write enables, one-hot |
| cfg_rdata_i | input | 8 | Selected configuration register data |
| ctrl_re_o | output | 1 | Control register read enable |
| ctrl_we_o | output | 1 | Control register write enable |
| ctrl_rdata_i | input | 8 | Control register data |
| clkp_we_o | output | 1 | Clock-programming register write enable |
| mcr_we_o | output | 1 | Modem-control bit write enable |
| uart_re_o | output | 1 | UART register read enable |
| uart_idx_o | output | 3 | UART register index |
| uart_rdata_i | input | 8 | UART register data |
| txf_re_o | output | 1 | Transmit FIFO read enable |
| rxf_we_o | output | 1 | Receive FIFO write enable |
| txf_rdata_i | input | 8 | Transmit FIFO data |

## Verification
The assertions assume that the mode inputs only change while no strobe is active. They also assume that the address lines are steady through the clock edge that sees the latch or address strobe change, since the capture reads them at that edge. The bench changes modes only between accesses and drives every input on the falling clock edge. It keeps the address on the bus for a full cycle around each latch edge, and it replaces the shared lines with unrelated data before the data strobe so that a held address can be told apart from a recaptured one.

// File: rtl/subsys_dec_pkg.sv
package subsys_dec_pkg;
   typedef enum logic [2:0] {
      RG_NONE = 3'd0,
      RG_RAM  = 3'd1,
      RG_CFG  = 3'd2,
      RG_CTRL = 3'd3,
      RG_CLKP = 3'd4,
      RG_UART = 3'd5,
      RG_FIFO = 3'd6
   } region_e;

   typedef struct packed {
      logic rd;
      logic wr;
   } access_t;
endpackage

// File: rtl/sd_addr_latch.sv
module sd_addr_latch #(
   parameter int ADDR_W = 9,
   parameter int LO_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nomux_i,
   input  logic              zstyle_i,
   input  logic              ale_i,
   input  logic              addr_hi_i,
   input  logic [LO_W-1:0]   ad_i,
   input  logic [LO_W-1:0]   addr_lo_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int HI_W = ADDR_W - LO_W;

   generate
      if (HI_W != 1) begin : g_bad_width
         $error("sd_addr_latch: ADDR_W must be LO_W + 1");
      end
   endgenerate

   logic              ale_q;
   logic [ADDR_W-1:0] addr_q;
   logic              cap;

   // Intel: latch on falling pulse; Zilog: latch on rising address strobe
   always_comb begin
      if (zstyle_i) cap = ale_i & ~ale_q;
      else          cap = ~ale_i & ale_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ale_q  <= ale_i;
         addr_q <= '0;
      end else begin
         ale_q <= ale_i;
         if (!nomux_i && cap) addr_q <= {addr_hi_i, ad_i};
      end
   end

   assign addr_o = nomux_i ? {addr_hi_i, addr_lo_i} : addr_q;
endmodule

// File: rtl/sd_strobe.sv
module sd_strobe
   import subsys_dec_pkg::*;
(
   input  logic    zstyle_i,
   input  logic    rd_ds_n_i,
   input  logic    wr_rnw_i,
   output access_t acc_o
);
   always_comb begin
      if (zstyle_i) begin
         acc_o.rd = ~rd_ds_n_i &  wr_rnw_i;
         acc_o.wr = ~rd_ds_n_i & ~wr_rnw_i;
      end else begin
         acc_o.rd = ~rd_ds_n_i &  wr_rnw_i;
         acc_o.wr = ~wr_rnw_i  &  rd_ds_n_i;
      end
   end
endmodule

// File: rtl/sd_region.sv
module sd_region
   import subsys_dec_pkg::*;
#(
   parameter int ADDR_W    = 9,
   parameter int RAM_WORDS = 256,
   parameter int CFG_BASE  = 256,
   parameter int NUM_CFG   = 8,
   parameter int CTRL_ADR  = 272,
   parameter int CLKP_ADR  = 288,
   parameter int UART_BASE = 304,
   parameter int NUM_UART  = 8,
   parameter int FIFO_ADR  = 320,
   parameter int IDX_W     = 3
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              bypass_i,
   output region_e           region_o,
   output logic [IDX_W-1:0]  idx_o
);
   localparam int ADR_SPAN = 1 << ADDR_W;

   generate
      if (FIFO_ADR >= ADR_SPAN || UART_BASE + NUM_UART > ADR_SPAN) begin : g_bad_map
         $error("sd_region: map does not fit the address width");
      end
      if (NUM_CFG > (1 << IDX_W) || NUM_UART > (1 << IDX_W)) begin : g_bad_idx
         $error("sd_region: index width too small");
      end
   endgenerate

   int unsigned a;

   always_comb begin
      a        = 32'(addr_i);
      region_o = RG_NONE;
      idx_o    = '0;
      if (a < RAM_WORDS) begin
         region_o = RG_RAM;
      end else if (a >= CFG_BASE && a < CFG_BASE + NUM_CFG) begin
         region_o = RG_CFG;
         idx_o    = IDX_W'(a - CFG_BASE);
      end else if (a == CTRL_ADR) begin
         region_o = RG_CTRL;
      end else if (a == CLKP_ADR) begin
         region_o = RG_CLKP;
      end else if (a >= UART_BASE && a < UART_BASE + NUM_UART) begin
         region_o = RG_UART;
         idx_o    = IDX_W'(a - UART_BASE);
      end else if (a == FIFO_ADR && bypass_i) begin
         region_o = RG_FIFO;
      end
   end
endmodule

// File: rtl/subsys_bus_decoder.sv
module subsys_bus_decoder
   import subsys_dec_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 9,
   parameter int NUM_CFG   = 8,
   parameter int IDX_W     = 3,
   parameter int RAM_WORDS = 256,
   parameter int CFG_BASE  = 256,
   parameter int CTRL_ADR  = 272,
   parameter int CLKP_ADR  = 288,
   parameter int UART_BASE = 304,
   parameter int FIFO_ADR  = 320
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nomux_i,
   input  logic              zstyle_i,
   input  logic              ale_i,
   input  logic              rd_ds_n_i,
   input  logic              wr_rnw_i,
   input  logic              addr_hi_i,
   input  logic [DATA_W-1:0] addr_lo_i,
   input  logic [DATA_W-1:0] ad_i,
   output logic [DATA_W-1:0] ad_out_o,
   output logic              ad_oe_o,
   input  logic              bypass_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              ram_re_o,
   output logic              ram_we_o,
   input  logic [DATA_W-1:0] ram_rdata_i,
   output logic [NUM_CFG-1:0] cfg_re_o,
   output logic [NUM_CFG-1:0] cfg_we_o,
   input  logic [DATA_W-1:0] cfg_rdata_i,
   output logic              ctrl_re_o,
   output logic              ctrl_we_o,
   input  logic [DATA_W-1:0] ctrl_rdata_i,
   output logic              clkp_we_o,
   output logic              mcr_we_o,
   output logic              uart_re_o,
   output logic [IDX_W-1:0]  uart_idx_o,
   input  logic [DATA_W-1:0] uart_rdata_i,
   output logic              txf_re_o,
   output logic              rxf_we_o,
   input  logic [DATA_W-1:0] txf_rdata_i
);
   localparam int NUM_UART = 1 << IDX_W;

   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("subsys_bus_decoder: DATA_W must be 8");
      end
      if (ADDR_W != DATA_W + 1) begin : g_bad_addr
         $error("subsys_bus_decoder: ADDR_W must be DATA_W + 1");
      end
   endgenerate

   access_t          acc;
   region_e          region;
   logic [IDX_W-1:0] idx;
   logic             readable;

   sd_addr_latch #(.ADDR_W(ADDR_W), .LO_W(DATA_W)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .nomux_i   (nomux_i),
      .zstyle_i  (zstyle_i),
      .ale_i     (ale_i),
      .addr_hi_i (addr_hi_i),
      .ad_i      (ad_i),
      .addr_lo_i (addr_lo_i),
      .addr_o    (addr_o)
   );

   sd_strobe u_strobe (
      .zstyle_i  (zstyle_i),
      .rd_ds_n_i (rd_ds_n_i),
      .wr_rnw_i  (wr_rnw_i),
      .acc_o     (acc)
   );

   sd_region #(
      .ADDR_W    (ADDR_W),
      .RAM_WORDS (RAM_WORDS),
      .CFG_BASE  (CFG_BASE),
      .NUM_CFG   (NUM_CFG),
      .CTRL_ADR  (CTRL_ADR),
      .CLKP_ADR  (CLKP_ADR),
      .UART_BASE (UART_BASE),
      .NUM_UART  (NUM_UART),
      .FIFO_ADR  (FIFO_ADR),
      .IDX_W     (IDX_W)
   ) u_region (
      .addr_i   (addr_o),
      .bypass_i (bypass_i),
      .region_o (region),
      .idx_o    (idx)
   );

   logic rst_ok;
   assign rst_ok = rst_n;

   always_comb begin
      ram_re_o   = rst_ok & acc.rd & (region == RG_RAM);
      ram_we_o   = rst_ok & acc.wr & (region == RG_RAM);
      ctrl_re_o  = rst_ok & acc.rd & (region == RG_CTRL);
      ctrl_we_o  = rst_ok & acc.wr & (region == RG_CTRL);
      clkp_we_o  = rst_ok & acc.wr & (region == RG_CLKP);
      mcr_we_o   = rst_ok & acc.wr & (region == RG_UART) & (idx == '0);
      uart_re_o  = rst_ok & acc.rd & (region == RG_UART);
      txf_re_o   = rst_ok & acc.rd & (region == RG_FIFO);
      rxf_we_o   = rst_ok & acc.wr & (region == RG_FIFO);
      uart_idx_o = (region == RG_UART) ? idx : '0;
   end

   generate
      for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg_en
         assign cfg_re_o[g] = rst_ok & acc.rd & (region == RG_CFG) & (idx == IDX_W'(g));
         assign cfg_we_o[g] = rst_ok & acc.wr & (region == RG_CFG) & (idx == IDX_W'(g));
      end
   endgenerate

   always_comb begin
      readable = 1'b1;
      ad_out_o = '0;
      unique case (region)
         RG_RAM:  ad_out_o = ram_rdata_i;
         RG_CFG:  ad_out_o = cfg_rdata_i;
         RG_CTRL: ad_out_o = ctrl_rdata_i;
         RG_UART: ad_out_o = uart_rdata_i;
         RG_FIFO: ad_out_o = txf_rdata_i;
         default: readable = 1'b0;
      endcase
      ad_oe_o = rst_ok & acc.rd & readable;
      if (!ad_oe_o) ad_out_o = '0;
   end

   assign wdata_o = ad_i;
endmodule

// File: rtl/subsys_bus_decoder_chk.sv
module subsys_bus_decoder_chk #(
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 9,
   parameter int NUM_CFG = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              nomux_i,
   input logic              zstyle_i,
   input logic              ale_i,
   input logic              rd_ds_n_i,
   input logic              wr_rnw_i,
   input logic              addr_hi_i,
   input logic [DATA_W-1:0] addr_lo_i,
   input logic              bypass_i,
   input logic [ADDR_W-1:0] addr_o,
   input logic [DATA_W-1:0] ad_out_o,
   input logic              ad_oe_o,
   input logic              ram_re_o,
   input logic              ram_we_o,
   input logic [NUM_CFG-1:0] cfg_re_o,
   input logic [NUM_CFG-1:0] cfg_we_o,
   input logic              ctrl_re_o,
   input logic              ctrl_we_o,
   input logic              clkp_we_o,
   input logic              mcr_we_o,
   input logic              uart_re_o,
   input logic              txf_re_o,
   input logic              rxf_we_o
);
   p_nomux_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      nomux_i |-> addr_o == {addr_hi_i, addr_lo_i});

   p_hold_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!nomux_i && !zstyle_i && !$fell(ale_i)) |=> (nomux_i || $stable(addr_o)));

   p_hold_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!nomux_i && zstyle_i && !$rose(ale_i)) |=> (nomux_i || $stable(addr_o)));

   p_bypass_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !bypass_i |-> !(txf_re_o || rxf_we_o));

   p_idle_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !ad_oe_o |-> ad_out_o == '0);

   p_oe_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe_o |-> (!rd_ds_n_i && wr_rnw_i));

   p_single_en_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ram_re_o, ram_we_o, |cfg_re_o, |cfg_we_o, ctrl_re_o, ctrl_we_o,
                clkp_we_o, mcr_we_o, uart_re_o, txf_re_o, rxf_we_o}));

   p_cfg_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cfg_re_o, cfg_we_o}));

   p_no_write_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!zstyle_i && !rd_ds_n_i && !wr_rnw_i) |-> !(ram_we_o || ram_re_o || ad_oe_o));
endmodule

bind subsys_bus_decoder subsys_bus_decoder_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CFG(NUM_CFG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .nomux_i(nomux_i), .zstyle_i(zstyle_i),
   .ale_i(ale_i), .rd_ds_n_i(rd_ds_n_i), .wr_rnw_i(wr_rnw_i),
   .addr_hi_i(addr_hi_i), .addr_lo_i(addr_lo_i), .bypass_i(bypass_i),
   .addr_o(addr_o), .ad_out_o(ad_out_o), .ad_oe_o(ad_oe_o),
   .ram_re_o(ram_re_o), .ram_we_o(ram_we_o), .cfg_re_o(cfg_re_o),
   .cfg_we_o(cfg_we_o), .ctrl_re_o(ctrl_re_o), .ctrl_we_o(ctrl_we_o),
   .clkp_we_o(clkp_we_o), .mcr_we_o(mcr_we_o), .uart_re_o(uart_re_o),
   .txf_re_o(txf_re_o), .rxf_we_o(rxf_we_o)
);

// File: tb/subsys_bus_decoder_tb.sv
module subsys_bus_decoder_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       nomux_i = 1'b0, zstyle_i = 1'b0, ale_i = 1'b0;
   logic       rd_ds_n_i = 1'b1, wr_rnw_i = 1'b1, addr_hi_i = 1'b0;
   logic [7:0] addr_lo_i = '0, ad_i = '0;
   logic [7:0] ad_out_o;
   logic       ad_oe_o, bypass_i = 1'b0;
   logic [8:0] addr_o;
   logic [7:0] wdata_o;
   logic       ram_re_o, ram_we_o, ctrl_re_o, ctrl_we_o, clkp_we_o, mcr_we_o;
   logic       uart_re_o, txf_re_o, rxf_we_o;
   logic [7:0] cfg_re_o, cfg_we_o;
   logic [2:0] uart_idx_o;
   logic [7:0] ram_rdata_i = 8'h11, cfg_rdata_i = 8'h22, ctrl_rdata_i = 8'h33;
   logic [7:0] uart_rdata_i = 8'h44, txf_rdata_i = 8'h55;

   int n_chk = 0, n_fail = 0;

   always #4 clk = ~clk;

   subsys_bus_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .nomux_i(nomux_i), .zstyle_i(zstyle_i),
      .ale_i(ale_i), .rd_ds_n_i(rd_ds_n_i), .wr_rnw_i(wr_rnw_i),
      .addr_hi_i(addr_hi_i), .addr_lo_i(addr_lo_i), .ad_i(ad_i),
      .ad_out_o(ad_out_o), .ad_oe_o(ad_oe_o), .bypass_i(bypass_i),
      .addr_o(addr_o), .wdata_o(wdata_o), .ram_re_o(ram_re_o),
      .ram_we_o(ram_we_o), .ram_rdata_i(ram_rdata_i), .cfg_re_o(cfg_re_o),
      .cfg_we_o(cfg_we_o), .cfg_rdata_i(cfg_rdata_i), .ctrl_re_o(ctrl_re_o),
      .ctrl_we_o(ctrl_we_o), .ctrl_rdata_i(ctrl_rdata_i), .clkp_we_o(clkp_we_o),
      .mcr_we_o(mcr_we_o), .uart_re_o(uart_re_o), .uart_idx_o(uart_idx_o),
      .uart_rdata_i(uart_rdata_i), .txf_re_o(txf_re_o), .rxf_we_o(rxf_we_o),
      .txf_rdata_i(txf_rdata_i)
   );

   // flags: ram_re ram_we cfg_re cfg_we ctrl_re ctrl_we clkp_we mcr_we uart_re txf_re rxf_we oe
   function automatic logic [11:0] exp_flags(input int a, input bit bp, input bit rd, input bit wr);
      logic [11:0] f = '0;
      if (a < 256)                 f = {rd, wr, 10'b0};
      else if (a < 264)            f = {2'b0, rd, wr, 8'b0};
      else if (a == 272)           f = {4'b0, rd, wr, 6'b0};
      else if (a == 288)           f = {6'b0, wr, 5'b0};
      else if (a >= 304 && a < 312) f = {7'b0, wr && a == 304, rd, 3'b0};
      else if (a == 320 && bp)     f = {9'b0, rd, wr, 1'b0};
      f[0] = rd && (a < 264 || a == 272 || (a >= 304 && a < 312) || (a == 320 && bp));
      return f;
   endfunction

   function automatic logic [7:0] exp_data(input int a, input bit bp, input bit rd);
      if (!rd) return 8'h00;
      if (a < 256) return ram_rdata_i;
      if (a < 264) return cfg_rdata_i;
      if (a == 272) return ctrl_rdata_i;
      if (a >= 304 && a < 312) return uart_rdata_i;
      if (a == 320 && bp) return txf_rdata_i;
      return 8'h00;
   endfunction

   function automatic string tag_of(input int a);
      if (a < 256) return "R6";
      if (a < 264) return "R7";
      if (a == 272 || a == 288) return "R8";
      if (a >= 304 && a < 312) return "R9";
      if (a == 320) return "R10";
      return "R11";
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic logic [11:0] got_flags();
      return {ram_re_o, ram_we_o, |cfg_re_o, |cfg_we_o, ctrl_re_o, ctrl_we_o,
              clkp_we_o, mcr_we_o, uart_re_o, txf_re_o, rxf_we_o, ad_oe_o};
   endfunction

   // mode: 0 Intel mux, 1 Zilog mux, 2 nonmux
   task automatic access(input int mode, input int a, input bit bp, input bit wr,
                         input string stag);
      logic [11:0] ef;
      logic [7:0]  ecfg;
      @(negedge clk);
      bypass_i  = bp;
      nomux_i   = (mode == 2);
      zstyle_i  = (mode == 1);
      ale_i     = (mode == 1);
      @(negedge clk);
      addr_hi_i = a[8];
      if (mode == 2) begin
         addr_lo_i = a[7:0];
         ad_i      = 8'($urandom);
         ale_i     = $urandom_range(1);
      end else begin
         ad_i  = a[7:0];
         ale_i = (mode == 0);
      end
      @(negedge clk);
      if (mode == 0) ale_i = 1'b0;
      if (mode == 1) ale_i = 1'b1;
      if (mode == 2) ale_i = ~ale_i;
      @(negedge clk);
      ad_i = 8'($urandom);
      if (mode != 2) addr_hi_i = $urandom_range(1);
      else ale_i = ~ale_i;
      ram_rdata_i  = 8'($urandom);
      cfg_rdata_i  = 8'($urandom);
      ctrl_rdata_i = 8'($urandom);
      uart_rdata_i = 8'($urandom);
      txf_rdata_i  = 8'($urandom);
      if (mode == 1) begin
         wr_rnw_i  = ~wr;
         rd_ds_n_i = 1'b0;
      end else begin
         if (wr) wr_rnw_i = 1'b0; else rd_ds_n_i = 1'b0;
      end
      #2;
      check(addr_o == 9'(a), (mode == 2) ? "R1" : (mode == 1) ? "R3" : "R2",
            32'(addr_o), 32'(a));
      ef = exp_flags(a, bp, !wr, wr);
      check(got_flags() == ef, stag, 32'(got_flags()), 32'(ef));
      check(ad_out_o == exp_data(a, bp, !wr), stag, 32'(ad_out_o),
            32'(exp_data(a, bp, !wr)));
      ecfg = (a >= 256 && a < 264) ? 8'(1 << (a - 256)) : 8'h00;
      check((wr ? cfg_we_o : cfg_re_o) == ecfg, "R7", 32'(wr ? cfg_we_o : cfg_re_o), 32'(ecfg));
      if (a >= 304 && a < 312 && !wr)
         check(uart_idx_o == 3'(a - 304), "R9", 32'(uart_idx_o), 32'(a - 304));
      if (wr) check(wdata_o == ad_i, "R6", 32'(wdata_o), 32'(ad_i));
      @(negedge clk);
      rd_ds_n_i = 1'b1;
      wr_rnw_i  = 1'b1;
      #2;
      check(got_flags() == 12'h000, "R12", 32'(got_flags()), 32'h0);
   endtask

   function automatic int pick_addr();
      case ($urandom_range(6))
         0: return $urandom_range(255);
         1: return 256 + $urandom_range(7);
         2: return 272;
         3: return 288;
         4: return 304 + $urandom_range(7);
         5: return 320;
         default: return $urandom_range(511);
      endcase
   endfunction

   bit done = 1'b0;

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      check(addr_o == 9'd0, "R13", 32'(addr_o), 32'h0);
      rd_ds_n_i = 1'b0;
      #1;
      check(got_flags() == 12'h000, "R13", 32'(got_flags()), 32'h0);
      rd_ds_n_i = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;

      // directed corners
      access(0, 5,   0, 0, "R6");
      access(0, 300, 0, 1, "R6");  // wait: not mapped
      access(1, 263, 0, 1, "R7");
      access(1, 272, 0, 0, "R8");
      access(2, 288, 0, 1, "R8");
      access(2, 288, 0, 0, "R11");
      access(0, 304, 0, 1, "R9");
      access(0, 305, 0, 1, "R11");
      access(1, 311, 0, 0, "R9");
      access(0, 320, 1, 0, "R10");
      access(1, 320, 1, 1, "R10");
      access(2, 320, 0, 0, "R10");
      access(0, 320, 0, 1, "R10");
      access(2, 500, 0, 0, "R11");

      // Intel: both strobes low gives no access
      @(negedge clk);
      nomux_i = 1'b1; zstyle_i = 1'b0; addr_hi_i = 1'b0; addr_lo_i = 8'd9;
      rd_ds_n_i = 1'b0; wr_rnw_i = 1'b0;
      #2;
      check(got_flags() == 12'h000, "R4", 32'(got_flags()), 32'h0);
      @(negedge clk);
      rd_ds_n_i = 1'b1; wr_rnw_i = 1'b1;

      // Zilog: data strobe high means no access regardless of level
      @(negedge clk);
      zstyle_i = 1'b1; wr_rnw_i = 1'b0;
      #2;
      check(got_flags() == 12'h000, "R5", 32'(got_flags()), 32'h0);
      @(negedge clk);
      wr_rnw_i = 1'b1;

      for (int i = 0; i < 400; i++) begin
         int a;
         a = pick_addr();
         access($urandom_range(2), a, $urandom_range(1), $urandom_range(1), tag_of(a));
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R12 got=running exp=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule